// File: doc/BRIEF.md
# Motor driver fault supervisor

This block watches the digital outputs of the analog protection detectors around an H-bridge motor driver and turns them into status bits, a bridge-disable command and an active-low fault pin. It deals with four fault kinds, and each kind recovers in its own way. A persistent current limit only raises a warning, and the bridge keeps driving. An overcurrent stays latched until software clears it. Overtemperature and undervoltage clear by themselves as soon as the detector releases.

The raw sense-resistor comparator first goes through a qualification filter. The filtered signal, `ilim_req`, asks the PWM stage to cut back its duty cycle. A second, much longer timer watches `ilim_req`. When `ilim_req` has stayed high for the whole persistence window, the block raises the current-limit status bit. That bit clears when both direction bits are equal (coast or brake), when a clear strobe arrives, or on reset. Both time windows are parameters counted in clock cycles. The default parameter values give 3 µs and 275 ms at 100 MHz.

The persistence timer is a state machine with three states:
- `IL_IDLE`: no limit is being timed.
- `IL_TIMING`: a qualified limit is being counted.
- `IL_FLAGGED`: the current-limit status is set.

Its transitions are:
- `start`: `IL_IDLE` to `IL_TIMING`, on `ilim_req` with no clear condition.
- `expire`: `IL_TIMING` to `IL_FLAGGED`, when the count reaches the window.
- `abort`: `IL_TIMING` to `IL_IDLE`, when `ilim_req` drops or a clear condition is present.
- `release`: `IL_FLAGGED` to `IL_IDLE`, on a clear condition.
- `direct`: `IL_IDLE` to `IL_FLAGGED`, used only when the window is one cycle.

Top module: `mdrv_fault_sup`

## Requirements
- R1: While `rst_n` is low, every status bit, `ilim_req` and `bridge_dis` are 0, and `fault_n` is 1.
- R2: `ilim_req` is 1 in the cycle after `sense_raw` has been sampled high on QUAL_CYC consecutive clock edges. It stays 1 while `sense_raw` remains high.
- R3: A single low sample of `sense_raw` restarts the qualification, and `ilim_req` is 0 in the following cycle.
- R4: `stat_ilim` becomes 1 after `ilim_req` has been sampled high on PERSIST_CYC consecutive edges with no clear condition present. `stat_ilim` alone never asserts `bridge_dis`.
- R5: If `ilim_req` is sampled low at any edge before the window expires, the persistence count restarts from zero.
- R6: A clear condition resets `stat_ilim` to 0 at the next edge and overrides any set at that same edge. A clear condition is any of: `dir_a == dir_b` (00 coast or 11 brake), or `clr_stb` = 1. While the condition holds, no timing takes place.
- R7: `stat_ocp` is set at the edge after `ocp_raw` is sampled 1. It stays set until an edge where `clr_stb` = 1 and `ocp_raw` = 0.
- R8: `stat_ots` and `stat_uvlo` follow `ots_raw` and `uvlo_raw` with one cycle of delay, with no latching.
- R9: `bridge_dis` is 1 exactly when `stat_ocp`, `stat_ots` or `stat_uvlo` is 1.
- R10: `stat_any` is the OR of the four status bits.
- R11: `fault_n` is a register that holds the inverse of `stat_any` from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sense_raw | input | 1 | Raw current-sense comparator output |
| ocp_raw | input | 1 | Overcurrent detector output |
| ots_raw | input | 1 | Overtemperature detector output |
| uvlo_raw | input | 1 | Undervoltage detector output |
| dir_a | input | 1 | Bridge direction bit A |
| dir_b | input | 1 | Bridge direction bit B |
| clr_stb | input | 1 | Fault clear command, one cycle |
| ilim_req | output | 1 | Qualified current-limit request to the PWM |
| stat_ilim | output | 1 | Persistent current-limit status |
| stat_ocp | output | 1 | Latched overcurrent status |
| stat_ots | output | 1 | Overtemperature status |
| stat_uvlo | output | 1 | Undervoltage status |
| stat_any | output | 1 | Any fault present |
| bridge_dis | output | 1 | Disable all bridge FETs |
| fault_n | output | 1 | Active-low fault pin, registered |

## Verification
The assertions assume that every input is already synchronous to `clk` and is stable around the rising edge. They also assume that `clr_stb` is an ordinary level sampled at each edge, with no pulse-width rule. The stimulus keeps within these limits by changing all inputs only at falling edges. Direction changes, clear strobes and the detector bits are applied in deliberate combinations, such as a clear while overcurrent is still present, or a limit that drops one edge before expiry. A seeded random phase then mixes long and short sense runs.

// File: rtl/mdrv_fault_pkg.sv
package mdrv_fault_pkg;

    // States of the current-limit persistence timer
    typedef enum logic [1:0] {
        IL_IDLE    = 2'd0,
        IL_TIMING  = 2'd1,
        IL_FLAGGED = 2'd2
    } ilim_state_t;

endpackage

// File: rtl/mdrv_ilim_qual.sv
// Qualification filter for the raw sense comparator.
module mdrv_ilim_qual #(
    parameter int QUAL_CYC = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sense_raw,
    output logic ilim_req
);
    localparam int QW = $clog2(QUAL_CYC + 1);
    localparam logic [QW-1:0] QMAX = QW'(QUAL_CYC);

    logic [QW-1:0] run_cnt;

    // Counts consecutive high samples and saturates at QMAX
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (!sense_raw) begin
            run_cnt <= '0;
        end else if (run_cnt != QMAX) begin
            run_cnt <= run_cnt + QW'(1);
        end
    end

    assign ilim_req = (run_cnt == QMAX);
endmodule

// File: rtl/mdrv_ilim_persist.sv
// Persistence timer for a qualified current limit.
module mdrv_ilim_persist
    import mdrv_fault_pkg::*;
#(
    parameter int PERSIST_CYC = 27_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ilim_req,
    input  logic clr_cond,
    output logic stat_ilim
);
    localparam int TW = $clog2(PERSIST_CYC + 1);
    localparam logic [TW-1:0] PLAST = TW'(PERSIST_CYC - 1);

    ilim_state_t   st, st_nxt;
    logic [TW-1:0] tmr, tmr_nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= IL_IDLE;
            tmr <= '0;
        end else begin
            st  <= st_nxt;
            tmr <= tmr_nxt;
        end
    end

    // Next-state logic
    always_comb begin
        st_nxt  = st;
        tmr_nxt = tmr;
        unique case (st)
            IL_IDLE: begin
                if (ilim_req && !clr_cond) begin
                    if (PERSIST_CYC <= 1) begin
                        st_nxt  = IL_FLAGGED;     // direct
                        tmr_nxt = '0;
                    end else begin
                        st_nxt  = IL_TIMING;      // start
                        tmr_nxt = TW'(1);
                    end
                end
            end
            IL_TIMING: begin
                if (clr_cond || !ilim_req) begin
                    st_nxt  = IL_IDLE;            // abort
                    tmr_nxt = '0;
                end else if (tmr == PLAST) begin
                    st_nxt  = IL_FLAGGED;         // expire
                    tmr_nxt = '0;
                end else begin
                    tmr_nxt = tmr + TW'(1);
                end
            end
            IL_FLAGGED: begin
                if (clr_cond) begin
                    st_nxt  = IL_IDLE;            // release
                    tmr_nxt = '0;
                end
            end
            default: begin
                st_nxt  = IL_IDLE;
                tmr_nxt = '0;
            end
        endcase
    end

    // Output decode
    always_comb begin
        stat_ilim = (st == IL_FLAGGED);
    end
endmodule

// File: rtl/mdrv_fault_regs.sv
// Latching, auto-resume and pin logic for the protection faults.
module mdrv_fault_regs #(
    parameter int N_AUTO = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ocp_raw,
    input  logic [N_AUTO-1:0] auto_raw,
    input  logic              clr_stb,
    input  logic              stat_ilim,
    output logic              stat_ocp,
    output logic [N_AUTO-1:0] auto_stat,
    output logic              stat_any,
    output logic              bridge_dis,
    output logic              fault_n
);
    // Overcurrent latch: a set from the detector wins over a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_ocp <= 1'b0;
        end else if (ocp_raw) begin
            stat_ocp <= 1'b1;
        end else if (clr_stb) begin
            stat_ocp <= 1'b0;
        end
    end

    // Auto-resume sources: one plain register stage each
    for (genvar i = 0; i < N_AUTO; i++) begin : g_auto
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                auto_stat[i] <= 1'b0;
            end else begin
                auto_stat[i] <= auto_raw[i];
            end
        end
    end

    assign bridge_dis = stat_ocp | (|auto_stat);
    assign stat_any   = bridge_dis | stat_ilim;

    // Registered fault pin, free of glitches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_n <= 1'b1;
        end else begin
            fault_n <= ~stat_any;
        end
    end
endmodule

// File: rtl/mdrv_fault_sup.sv
module mdrv_fault_sup #(
    parameter int QUAL_CYC    = 300,
    parameter int PERSIST_CYC = 27_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sense_raw,
    input  logic ocp_raw,
    input  logic ots_raw,
    input  logic uvlo_raw,
    input  logic dir_a,
    input  logic dir_b,
    input  logic clr_stb,
    output logic ilim_req,
    output logic stat_ilim,
    output logic stat_ocp,
    output logic stat_ots,
    output logic stat_uvlo,
    output logic stat_any,
    output logic bridge_dis,
    output logic fault_n
);
    logic       clr_cond;
    logic [1:0] auto_stat;

    // Coast (00) or brake (11) clears the limit fault, as does the strobe
    assign clr_cond = clr_stb | (dir_a ~^ dir_b);

    mdrv_ilim_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .sense_raw (sense_raw),
        .ilim_req  (ilim_req)
    );

    mdrv_ilim_persist #(.PERSIST_CYC(PERSIST_CYC)) u_persist (
        .clk       (clk),
        .rst_n     (rst_n),
        .ilim_req  (ilim_req),
        .clr_cond  (clr_cond),
        .stat_ilim (stat_ilim)
    );

    mdrv_fault_regs #(.N_AUTO(2)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ocp_raw    (ocp_raw),
        .auto_raw   ({uvlo_raw, ots_raw}),
        .clr_stb    (clr_stb),
        .stat_ilim  (stat_ilim),
        .stat_ocp   (stat_ocp),
        .auto_stat  (auto_stat),
        .stat_any   (stat_any),
        .bridge_dis (bridge_dis),
        .fault_n    (fault_n)
    );

    assign stat_ots  = auto_stat[0];
    assign stat_uvlo = auto_stat[1];
endmodule

// File: rtl/mdrv_fault_sup_chk.sv
module mdrv_fault_sup_chk (
    input logic clk,
    input logic rst_n,
    input logic sense_raw,
    input logic ocp_raw,
    input logic ots_raw,
    input logic uvlo_raw,
    input logic dir_a,
    input logic dir_b,
    input logic clr_stb,
    input logic ilim_req,
    input logic stat_ilim,
    input logic stat_ocp,
    input logic stat_ots,
    input logic stat_uvlo,
    input logic stat_any,
    input logic bridge_dis,
    input logic fault_n
);
    a_r3_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !sense_raw |=> !ilim_req);

    a_r4_warn_only: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_ilim && !stat_ocp && !stat_ots && !stat_uvlo) |-> !bridge_dis);

    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb || (dir_a == dir_b)) |=> !stat_ilim);

    a_r7_ocp_set: assert property (@(posedge clk) disable iff (!rst_n)
        ocp_raw |=> stat_ocp);

    a_r7_ocp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_ocp && !clr_stb) |=> stat_ocp);

    a_r8_ots_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stat_ots == $past(ots_raw)));

    a_r8_uvlo_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stat_uvlo == $past(uvlo_raw)));

    a_r11_pin: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (fault_n == !$past(stat_any)));
endmodule

bind mdrv_fault_sup mdrv_fault_sup_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sense_raw  (sense_raw),
    .ocp_raw    (ocp_raw),
    .ots_raw    (ots_raw),
    .uvlo_raw   (uvlo_raw),
    .dir_a      (dir_a),
    .dir_b      (dir_b),
    .clr_stb    (clr_stb),
    .ilim_req   (ilim_req),
    .stat_ilim  (stat_ilim),
    .stat_ocp   (stat_ocp),
    .stat_ots   (stat_ots),
    .stat_uvlo  (stat_uvlo),
    .stat_any   (stat_any),
    .bridge_dis (bridge_dis),
    .fault_n    (fault_n)
);

// File: tb/sim_mdrv_fault_sup.sv
`timescale 1ns/1ps
module sim_mdrv_fault_sup;
    localparam int Q = 4;
    localparam int P = 10;

    logic clk = 1'b0;
    logic rst_n, sense_raw, ocp_raw, ots_raw, uvlo_raw, dir_a, dir_b, clr_stb;
    logic ilim_req, stat_ilim, stat_ocp, stat_ots, stat_uvlo, stat_any, bridge_dis, fault_n;

    always #5 clk = ~clk;

    mdrv_fault_sup #(.QUAL_CYC(Q), .PERSIST_CYC(P)) u0 (
        .clk(clk), .rst_n(rst_n), .sense_raw(sense_raw), .ocp_raw(ocp_raw),
        .ots_raw(ots_raw), .uvlo_raw(uvlo_raw), .dir_a(dir_a), .dir_b(dir_b),
        .clr_stb(clr_stb), .ilim_req(ilim_req), .stat_ilim(stat_ilim),
        .stat_ocp(stat_ocp), .stat_ots(stat_ots), .stat_uvlo(stat_uvlo),
        .stat_any(stat_any), .bridge_dis(bridge_dis), .fault_n(fault_n)
    );

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;

    // Behavioural reference model
    int qc, pc;
    bit m_il, m_oc, m_ot, m_uv, m_fn;

    always @(posedge clk) begin
        bit req_now, clr_il, any_old;
        if (!rst_n) begin
            qc = 0; pc = 0; m_il = 0; m_oc = 0; m_ot = 0; m_uv = 0; m_fn = 1;
        end else begin
            req_now = (qc >= Q);
            clr_il  = clr_stb || (dir_a == dir_b);
            any_old = m_il | m_oc | m_ot | m_uv;
            m_fn    = !any_old;
            if (clr_il) begin
                m_il = 0; pc = 0;
            end else if (!m_il) begin
                if (req_now) begin
                    pc = pc + 1;
                    if (pc >= P) m_il = 1;
                end else begin
                    pc = 0;
                end
            end
            if (ocp_raw) m_oc = 1;
            else if (clr_stb) m_oc = 0;
            m_ot = ots_raw;
            m_uv = uvlo_raw;
            qc = sense_raw ? ((qc + 1 > Q) ? Q : qc + 1) : 0;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cmp_all();
        chk("R2 ilim_req",    ilim_req,   (qc >= Q));
        chk("R4 stat_ilim",   stat_ilim,  m_il);
        chk("R7 stat_ocp",    stat_ocp,   m_oc);
        chk("R8 stat_ots",    stat_ots,   m_ot);
        chk("R8 stat_uvlo",   stat_uvlo,  m_uv);
        chk("R9 bridge_dis",  bridge_dis, m_oc | m_ot | m_uv);
        chk("R10 stat_any",   stat_any,   m_il | m_oc | m_ot | m_uv);
        chk("R11 fault_n",    fault_n,    m_fn);
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rst_n) cmp_all();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; sense_raw = 0; ocp_raw = 0; ots_raw = 0; uvlo_raw = 0;
        dir_a = 0; dir_b = 0; clr_stb = 0;
        // R1: reset state
        sense_raw = 1; ocp_raw = 1; ots_raw = 1; uvlo_raw = 1; dir_a = 1;
        tick(3);
        chk("R1 ilim_req",   ilim_req,   1'b0);
        chk("R1 stat_any",   stat_any,   1'b0);
        chk("R1 bridge_dis", bridge_dis, 1'b0);
        chk("R1 fault_n",    fault_n,    1'b1);
        chk("R1 stat_ocp",   stat_ocp,   1'b0);
        sense_raw = 0; ocp_raw = 0; ots_raw = 0; uvlo_raw = 0;
        rst_n = 1;
        tick(2);

        // R3: short sense runs never qualify
        sense_raw = 1; tick(Q - 1);
        sense_raw = 0; tick(1);
        sense_raw = 1; tick(Q - 1);
        chk("R3 ilim_req short runs", ilim_req, 1'b0);
        sense_raw = 0; tick(2);

        // R2, R4: long run qualifies, then flags without disabling
        sense_raw = 1; tick(Q);
        chk("R2 ilim_req qualified", ilim_req, 1'b1);
        tick(P + 1);
        chk("R4 stat_ilim set", stat_ilim, 1'b1);
        chk("R4 bridge stays on", bridge_dis, 1'b0);
        tick(1);
        chk("R11 fault_n low", fault_n, 1'b0);

        // R6: clear by coast, brake and strobe
        dir_b = 0; dir_a = 0; tick(1);
        chk("R6 coast clears", stat_ilim, 1'b0);
        tick(3);
        chk("R6 no timing in coast", stat_ilim, 1'b0);
        dir_a = 1; tick(P + 1);
        dir_b = 1; tick(1);
        chk("R6 brake clears", stat_ilim, 1'b0);
        dir_b = 0; tick(P + 1);
        clr_stb = 1; tick(1);
        clr_stb = 0;
        chk("R6 strobe clears", stat_ilim, 1'b0);
        sense_raw = 0; tick(2);

        // R5: limit drops just before expiry
        sense_raw = 1; tick(Q + P - 2);
        sense_raw = 0; tick(1);
        sense_raw = 1; tick(Q + P - 2);
        chk("R5 timer restarted", stat_ilim, 1'b0);
        sense_raw = 0; tick(2);

        // R7: overcurrent latch
        ocp_raw = 1; tick(1);
        ocp_raw = 0; tick(3);
        chk("R7 ocp latched", stat_ocp, 1'b1);
        chk("R9 ocp disables", bridge_dis, 1'b1);
        ocp_raw = 1; clr_stb = 1; tick(1);
        chk("R7 clear loses to active ocp", stat_ocp, 1'b1);
        ocp_raw = 0; tick(1);
        clr_stb = 0;
        chk("R7 ocp cleared", stat_ocp, 1'b0);
        tick(2);

        // R8: auto-resume faults
        ots_raw = 1; tick(2);
        chk("R8 ots set", stat_ots, 1'b1);
        ots_raw = 0; tick(1);
        chk("R8 ots resumes", stat_ots, 1'b0);
        uvlo_raw = 1; tick(2);
        chk("R8 uvlo set", stat_uvlo, 1'b1);
        chk("R9 uvlo disables", bridge_dis, 1'b1);
        uvlo_raw = 0; tick(1);
        chk("R8 uvlo resumes", stat_uvlo, 1'b0);
        tick(2);

        // Mixed random phase, compared every cycle
        for (int k = 0; k < 3000; k++) begin
            if ($urandom_range(0, 15) == 0) sense_raw = ~sense_raw;
            ocp_raw  = ($urandom_range(0, 199) == 0);
            ots_raw  = ($urandom_range(0, 99) < 3) ? ~ots_raw : ots_raw;
            uvlo_raw = ($urandom_range(0, 99) < 2) ? ~uvlo_raw : uvlo_raw;
            clr_stb  = ($urandom_range(0, 63) == 0);
            if ($urandom_range(0, 127) == 0) begin
                dir_a = $urandom_range(0, 1);
                dir_b = $urandom_range(0, 1);
            end
            tick(1);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule